// File: doc/BRIEF.md
# SPI clock prescaler search engine

This block picks the setting of a two-field SPI clock prescaler. The serial clock is the core clock divided by `mult << shift`, where the multiplier runs from 1 to 15 and the shift from 0 to 7. Given the core clock frequency and the highest serial clock frequency a device accepts, the engine tries the settings one after another. It returns the setting whose serial clock comes closest to the limit without going above it.

A one-cycle `start_i` pulse latches both frequencies and begins the search. Each candidate's frequency is the truncated integer quotient of the core clock over the divider. A serial restoring divider computes it, so a candidate costs a fixed number of cycles. The search stops as soon as one candidate hits the limit exactly. Otherwise it runs through every candidate. When it ends, `done_o` pulses and the result appears on `mult_o`, `shift_o` and `err_o`. Software or a configuration sequencer then copies the result into the prescaler register.

Top module: `spi_prescale_search`

## Requirements
- R1: Candidates are tried with the multiplier as the outer loop, ascending from 1 to 15, and the shift as the inner loop, ascending from 0 to 7. The divider of a candidate is the multiplier shifted left by the shift.
- R2: A candidate's frequency is floor(core / divider). A candidate whose frequency is above the limit is never chosen.
- R3: The first candidate whose frequency equals the limit exactly is the result, and the search ends in that candidate's evaluation without trying any later one.
- R4: Without an exact hit, a candidate replaces the current best only when its shortfall (limit minus frequency) is strictly smaller. On equal shortfall the earlier candidate stays.
- R5: At the start of each search the best shortfall is all ones. A candidate whose shortfall is all ones therefore never becomes the best.
- R6: If no candidate is accepted, `err_o` is 1 and `mult_o` and `shift_o` are 0. Otherwise `err_o` is 0.
- R7: `done_o` is high for exactly one cycle per search. `mult_o`, `shift_o` and `err_o` keep their values from then until the next search finishes.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The running search keeps its latched frequencies and its result.
- R9: After a synchronous active-low reset, `busy_o`, `done_o`, `err_o`, `mult_o` and `shift_o` are all 0. A reset during a search abandons that search.
- R10: `busy_o` rises in the cycle after an accepted start and falls in the same cycle that `done_o` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only while idle |
| core_hz_i | input | 32 | Core clock frequency, sampled on an accepted start |
| max_hz_i | input | 32 | Highest allowed serial clock frequency, sampled on an accepted start |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| mult_o | output | 4 | Chosen multiplier, 1 to 15 (0 on error) |
| shift_o | output | 3 | Chosen shift, 0 to 7 (0 on error) |
| err_o | output | 1 | No candidate was accepted |

## Verification
Two exit conditions can fall in the same evaluation cycle: the exact-hit exit and the end of the candidate range. The bench provokes this with a core clock of 3,840,000 and a limit of 2000. Every earlier divider then gives a quotient above the limit, and only the last candidate (15, 7) gives exactly 2000. The bench expects a single done pulse, the result (15, 7) with no error, and a latency equal to the full walk. A second case lines up a start pulse with a running search, and the bench checks that the result still belongs to the first set of frequencies.

// File: rtl/spi_psc_pkg.sv
// Package: shared widths, candidate bounds and the controller state type
// for the SPI prescaler search engine.
package spi_psc_pkg;
    localparam int FREQ_W     = 32;  // width of the frequency operands
    localparam int MULT_W     = 4;   // width of the multiplier field
    localparam int SHIFT_W    = 3;   // width of the shift field
    localparam int MULT_FIRST = 1;   // first multiplier tried
    localparam int MULT_LAST  = 15;  // last multiplier tried
    localparam int SHIFT_LAST = 7;   // last shift tried per multiplier

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_WAIT,
        ST_EVAL
    } psc_state_e;
endpackage

// File: rtl/psc_restoring_div.sv
// Module: unsigned restoring divider, one quotient bit per cycle.
// The operation takes W cycles after start_i. done_o pulses once and
// quot_o holds until the next start.
// Assumes den_i is nonzero and start_i is not raised while a division runs.
module psc_restoring_div #(
    parameter int W = spi_psc_pkg::FREQ_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic         done_o,
    output logic [W-1:0] quot_o
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q, quo_q, den_q, num_q;
    logic [CW-1:0] cnt_q;
    logic          run_q, done_q;
    logic [W:0]    trial, rem_nx;
    logic          fits;

    // Trial subtraction of the divisor from the shifted partial remainder
    always_comb begin
        trial  = {rem_q, quo_q[W-1]};
        fits   = trial >= {1'b0, den_q};
        rem_nx = fits ? (trial - {1'b0, den_q}) : trial;
    end

    // Iteration registers: load on start, then one quotient bit per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            num_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                rem_q <= '0;
                quo_q <= num_i;
                den_q <= den_i;
                num_q <= num_i;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= rem_nx[W-1:0];
                quo_q <= {quo_q[W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
    assign quot_o = quo_q;

    logic [2*W-1:0] recon;
    // Rebuilds the dividend from quotient, divisor and remainder for checking
    always_comb recon = {{W{1'b0}}, quo_q} * {{W{1'b0}}, den_q} + {{W{1'b0}}, rem_q};

    // R2: the partial remainder never needs more than W bits
    a_r2_rem_fits: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> !rem_nx[W]);
    // R2: the final quotient is the truncated quotient
    a_r2_quot_exact: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (recon == {{W{1'b0}}, num_q}) && (rem_q < den_q));
endmodule

// File: rtl/psc_cand_walker.sv
// Module: produces the candidate sequence with the multiplier as the outer
// loop and the shift as the inner loop, together with the candidate's divider.
// Assumes step_i is never raised when last_o is high.
module psc_cand_walker #(
    parameter int W          = spi_psc_pkg::FREQ_W,
    parameter int MULT_W     = spi_psc_pkg::MULT_W,
    parameter int SHIFT_W    = spi_psc_pkg::SHIFT_W,
    parameter int MULT_FIRST = spi_psc_pkg::MULT_FIRST,
    parameter int MULT_LAST  = spi_psc_pkg::MULT_LAST,
    parameter int SHIFT_LAST = spi_psc_pkg::SHIFT_LAST
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               step_i,
    output logic [MULT_W-1:0]  mult_o,
    output logic [SHIFT_W-1:0] shift_o,
    output logic               last_o,
    output logic [W-1:0]       divisor_o
);
    logic [MULT_W-1:0]  mult_q;
    logic [SHIFT_W-1:0] shift_q;

    // Candidate counters: the inner shift wraps into the outer multiplier
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            mult_q  <= MULT_W'(MULT_FIRST);
            shift_q <= '0;
        end else if (step_i) begin
            if (shift_q == SHIFT_W'(SHIFT_LAST)) begin
                shift_q <= '0;
                mult_q  <= mult_q + 1'b1;
            end else begin
                shift_q <= shift_q + 1'b1;
            end
        end
    end

    // Divider of the present candidate and the end-of-range flag
    always_comb begin
        divisor_o = W'(mult_q) << shift_q;
        last_o    = (mult_q == MULT_W'(MULT_LAST)) && (shift_q == SHIFT_W'(SHIFT_LAST));
    end

    assign mult_o  = mult_q;
    assign shift_o = shift_q;

    // R1: a step moves to the next shift, or wraps to the next multiplier
    a_r1_walk_order: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i) |=>
            ((mult_q == $past(mult_q)) && (shift_q == $past(shift_q) + 1'b1)) ||
            ((mult_q == $past(mult_q) + 1'b1) && (shift_q == '0)));
endmodule

// File: rtl/spi_prescale_search.sv
// Module: top of the SPI prescaler search engine. It walks every prescaler
// candidate, divides the core clock by each candidate's divider and keeps
// the one closest to the limit without exceeding it. An exact hit ends the
// search at once.
// Assumes start_i is a pulse. It is ignored while busy.
module spi_prescale_search #(
    parameter int W          = spi_psc_pkg::FREQ_W,
    parameter int MULT_W     = spi_psc_pkg::MULT_W,
    parameter int SHIFT_W    = spi_psc_pkg::SHIFT_W,
    parameter int MULT_FIRST = spi_psc_pkg::MULT_FIRST,
    parameter int MULT_LAST  = spi_psc_pkg::MULT_LAST,
    parameter int SHIFT_LAST = spi_psc_pkg::SHIFT_LAST
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [W-1:0]       core_hz_i,
    input  logic [W-1:0]       max_hz_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [MULT_W-1:0]  mult_o,
    output logic [SHIFT_W-1:0] shift_o,
    output logic               err_o
);
    import spi_psc_pkg::*;

    psc_state_e         state_q;
    logic [W-1:0]       core_q, max_q, best_short_q;
    logic [MULT_W-1:0]  best_mult_q, res_mult_q;
    logic [SHIFT_W-1:0] best_shift_q, res_shift_q;
    logic               err_q, done_q;

    logic               accept, in_eval, exact, below, better, finish, step;
    logic [W-1:0]       shortfall;
    logic [MULT_W-1:0]  cand_mult, sel_mult;
    logic [SHIFT_W-1:0] cand_shift, sel_shift;
    logic               cand_last;
    logic [W-1:0]       cand_div, quot;
    logic               div_done;

    psc_cand_walker #(
        .W(W), .MULT_W(MULT_W), .SHIFT_W(SHIFT_W),
        .MULT_FIRST(MULT_FIRST), .MULT_LAST(MULT_LAST), .SHIFT_LAST(SHIFT_LAST)
    ) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (accept),
        .step_i    (step),
        .mult_o    (cand_mult),
        .shift_o   (cand_shift),
        .last_o    (cand_last),
        .divisor_o (cand_div)
    );

    psc_restoring_div #(.W(W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (state_q == ST_LAUNCH),
        .num_i   (core_q),
        .den_i   (cand_div),
        .done_o  (div_done),
        .quot_o  (quot)
    );

    // Candidate verdict: exact hit, strict improvement and end of search
    always_comb begin
        accept    = start_i && (state_q == ST_IDLE);
        in_eval   = (state_q == ST_EVAL);
        exact     = (quot == max_q);
        below     = (quot < max_q);
        shortfall = max_q - quot;
        better    = below && (shortfall < best_short_q);
        finish    = in_eval && (exact || cand_last);
        step      = in_eval && !finish;
        sel_mult  = (exact || better) ? cand_mult  : best_mult_q;
        sel_shift = (exact || better) ? cand_shift : best_shift_q;
    end

    // Controller sequencing: launch a division, wait, then evaluate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (accept)   state_q <= ST_LAUNCH;
                ST_LAUNCH:               state_q <= ST_WAIT;
                ST_WAIT:   if (div_done) state_q <= ST_EVAL;
                ST_EVAL:   state_q <= finish ? ST_IDLE : ST_LAUNCH;
                default:                 state_q <= ST_IDLE;
            endcase
        end
    end

    // Search context: latched operands and the best candidate so far
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q       <= '0;
            max_q        <= '0;
            best_short_q <= '1;
            best_mult_q  <= '0;
            best_shift_q <= '0;
        end else if (accept) begin
            core_q       <= core_hz_i;
            max_q        <= max_hz_i;
            best_short_q <= '1;
            best_mult_q  <= '0;
            best_shift_q <= '0;
        end else if (in_eval && better) begin
            best_short_q <= shortfall;
            best_mult_q  <= cand_mult;
            best_shift_q <= cand_shift;
        end
    end

    // Result registers and the completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_mult_q  <= '0;
            res_shift_q <= '0;
            err_q       <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) begin
                res_mult_q  <= sel_mult;
                res_shift_q <= sel_shift;
                err_q       <= (sel_mult == '0);
            end
        end
    end

    assign busy_o  = (state_q != ST_IDLE);
    assign done_o  = done_q;
    assign mult_o  = res_mult_q;
    assign shift_o = res_shift_q;
    assign err_o   = err_q;

    // R7: done is a single-cycle pulse
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R7: results stay put while idle
    a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(res_mult_q) && $stable(res_shift_q) && $stable(err_q)));
    // R8: a start while busy leaves the latched operands untouched
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(core_q) && $stable(max_q)));
    // R4: within a search the best shortfall never grows
    a_r4_best_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> (best_short_q <= $past(best_short_q)));
    // R3: an exact hit ends the search in the next cycle
    a_r3_exact_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (in_eval && exact) |=> (done_q && !busy_o));
    // R10: busy is low whenever done is high
    a_r10_busy_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_o);
endmodule

// File: tb/tb_spi_prescale_search.sv
`timescale 1ns/1ps
module tb_spi_prescale_search;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [31:0] core_hz_i, max_hz_i;
    logic        busy_o, done_o, err_o;
    logic [3:0]  mult_o;
    logic [2:0]  shift_o;

    always #2.5 clk = ~clk;

    spi_prescale_search dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .core_hz_i(core_hz_i), .max_hz_i(max_hz_i),
        .busy_o(busy_o), .done_o(done_o),
        .mult_o(mult_o), .shift_o(shift_o), .err_o(err_o)
    );

    int checks = 0;
    int errors = 0;

    // {core, limit, expected multiplier, expected shift, expected error}
    localparam int NV = 12;
    localparam logic [71:0] VEC [NV] = '{
        {32'd100,        32'd100,        4'd1,  3'd0, 1'b0},
        {32'd100,        32'd30,         4'd1,  3'd2, 1'b0},
        {32'd1000,       32'd7,          4'd1,  3'd7, 1'b0},
        {32'd1000,       32'd333,        4'd3,  3'd0, 1'b0},
        {32'd100,        32'd45,         4'd3,  3'd0, 1'b0},
        {32'd10,         32'd0,          4'd1,  3'd4, 1'b0},
        {32'd100000,     32'd1,          4'd0,  3'd0, 1'b1},
        {32'd0,          32'hFFFF_FFFF,  4'd0,  3'd0, 1'b1},
        {32'd0,          32'd5,          4'd1,  3'd0, 1'b0},
        {32'hFFFF_FFFF,  32'hFFFF_FFFF,  4'd1,  3'd0, 1'b0},
        {32'd3840000,    32'd2000,       4'd15, 3'd7, 1'b0},
        {32'd200000000,  32'd10000000,   4'd5,  3'd2, 1'b0}
    };
    // Requirement exercised by each vector
    string vtag [NV] = '{"R3", "R4", "R2", "R1", "R4", "R2",
                         "R6", "R5", "R4", "R3", "R1", "R1"};

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // One accepted start, then wait for done. Samples are taken at negedges.
    task automatic run_search(input logic [31:0] c, input logic [31:0] m,
                              output int lat, output bit timed_out);
        @(negedge clk);
        start_i = 1'b1; core_hz_i = c; max_hz_i = m;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 6000) begin
            @(negedge clk);
            lat++;
        end
        timed_out = !done_o;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int  lat;
        bit  to;
        rst_n = 1'b0; start_i = 1'b0; core_hz_i = '0; max_hz_i = '0;
        repeat (4) @(negedge clk);
        // R9: reset state
        check(!busy_o && !done_o && !err_o && mult_o == 0 && shift_o == 0, "R9",
              "reset outputs", {busy_o, done_o, err_o, mult_o, shift_o}, 32'd0);
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [31:0] vc, vm;
            logic [3:0]  em;
            logic [2:0]  es;
            logic        ee;
            {vc, vm, em, es, ee} = VEC[i];
            run_search(vc, vm, lat, to);
            check(!to, "R7", "done seen", {31'd0, to}, 32'd0);
            check(!busy_o, "R10", "busy low with done", {31'd0, busy_o}, 32'd0);
            check(mult_o == em, vtag[i], "multiplier", {28'd0, mult_o}, {28'd0, em});
            check(shift_o == es, vtag[i], "shift", {29'd0, shift_o}, {29'd0, es});
            check(err_o == ee, (ee ? "R6" : vtag[i]), "error flag", {31'd0, err_o}, {31'd0, ee});
            @(negedge clk);
            check(!done_o, "R7", "done one cycle", {31'd0, done_o}, 32'd0);
            repeat (5) @(negedge clk);
            check(mult_o == em && shift_o == es && err_o == ee, "R7", "result held",
                  {mult_o, shift_o, err_o}, {em, es, ee});
            // R3: exact hit at the first candidate is fast, the range-end hit is slow
            if (i == 0)  check(lat < 70, "R3", "early exit latency", lat, 70);
            if (i == 10) check(lat > 4000, "R3", "last-candidate hit latency", lat, 4000);
        end

        // R10, R8: busy during a search, and a start while busy is ignored
        @(negedge clk);
        start_i = 1'b1; core_hz_i = 32'd100; max_hz_i = 32'd30;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o, "R10", "busy after start", {31'd0, busy_o}, 32'd1);
        repeat (10) @(negedge clk);
        start_i = 1'b1; core_hz_i = 32'd1000; max_hz_i = 32'd7;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 6000) begin
            @(negedge clk);
            lat++;
        end
        check(mult_o == 4'd1 && shift_o == 3'd2, "R8", "start while busy ignored",
              {mult_o, shift_o}, {4'd1, 3'd2});

        // R9: reset in the middle of a search
        @(negedge clk);
        start_i = 1'b1; core_hz_i = 32'd3840000; max_hz_i = 32'd2000;
        @(negedge clk);
        start_i = 1'b0;
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy_o && !done_o && mult_o == 0 && shift_o == 0 && !err_o, "R9",
              "mid-search reset", {busy_o, done_o, err_o, mult_o, shift_o}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        summary();
        $finish;
    end
endmodule